// File: doc/BRIEF.md
# In-Order Retirement History Buffer

This block keeps a circular record of every instruction in flight, so that a core which issues in program order and finishes out of order can still take precise exceptions. At issue, each instruction claims the tail slot. That slot holds the instruction address, the address of the instruction that follows it in program flow, the destination register index, and the value that register held before the write. Execution units later report completion by slot tag, together with a cause code that is zero for a clean finish. Only the oldest slot may leave the buffer, and it leaves only once it has finished.

When the oldest slot finishes with a nonzero cause, or an asynchronous interrupt request arrives, the block undoes speculative register writes. It walks the affected slots from youngest to oldest, restoring one register per cycle through a restore port. It then reports the return address to save and the cause. Which return address it picks depends on the class of the cause. Issue is held off from the decision cycle until the recovery completes.

Top module: `retire_history_buffer`

## Requirements
- R1: An accepted issue is written to the slot shown on `issueTag`. Successive accepted issues receive consecutive tags, wrapping from DEPTH-1 to 0.
- R2: `issueReady` is high only when the block is idle, fewer than DEPTH slots are occupied, and no recovery starts in that cycle. `bufFull` is high exactly when all DEPTH slots are occupied. An issue and a retirement may happen in the same cycle.
- R3: At most one slot retires per cycle, and it is always the oldest one. It retires only when it has finished with cause 0, and no asynchronous request is present in that cycle. `retireTag` and `retireAddr` report the slot.
- R4: A slot freed by retirement or rollback can be reused by an issue in a later cycle.
- R5: A finish report aimed at an unoccupied slot is ignored. A finish report that arrives while a rollback or its completion cycle is in progress is also ignored.
- R6: An exception is acted on only when its slot is the oldest one. An exception reported by a younger slot does not change the outcome: that slot is simply rolled back, and `recoverCause` reports the cause of the oldest slot.
- R7: Rollback drives `restoreValid` with the destination index and saved old value of one slot per cycle. It starts at the youngest slot, and no retirement or issue takes place during it.
- R8: Causes 1 to 8 and 12 to 15 (faulting-before class) roll back every slot up to and including the faulting one. The saved return address is the faulting instruction's address.
- R9: Causes 9 (system call) and 10 (trace) retire the faulting slot in the decision cycle and roll back only the younger slots. The saved return address is the next address stored with the faulting slot.
- R10: Cause 11 (data breakpoint) retires the faulting slot like R9, but the saved return address is the faulting address plus 4.
- R11: An asynchronous request, taken when the oldest slot has no exception, rolls back every occupied slot. The saved address is the oldest slot's address. If the buffer is empty, the saved address is the next address of the most recently retired slot, or RESET_ADDR when nothing has retired since reset. `recoverCause` equals `asyncCause`.
- R12: `recoverDone` is a one-cycle pulse. It comes in the cycle after the last restore, or in the cycle after the decision when nothing needs restoring. The buffer is empty afterwards.
- R13: After reset, the buffer is empty, issue is ready at tag 0, and the retire, restore and done outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueAddr | input | ADDR_W | Address of the issuing instruction |
| issueNextAddr | input | ADDR_W | Address of the instruction that follows in program flow |
| issueDest | input | IDX_W | Destination register index |
| issueOldVal | input | DATA_W | Destination value before this instruction |
| issueReady | output | 1 | Issue accepted this cycle if requested |
| issueTag | output | TAG_W | Slot that an issue in this cycle receives |
| bufFull | output | 1 | All slots occupied |
| finishValid | input | 1 | Finish report |
| finishTag | input | TAG_W | Slot of the finishing instruction |
| finishCause | input | CAUSE_W | 0 for a clean finish, otherwise the exception cause |
| asyncReq | input | 1 | Asynchronous interrupt request |
| asyncCause | input | CAUSE_W | Cause reported for the asynchronous request |
| retireValid | output | 1 | Oldest slot retires this cycle |
| retireTag | output | TAG_W | Tag of the retiring slot |
| retireAddr | output | ADDR_W | Address of the retiring instruction |
| restoreValid | output | 1 | Register restore strobe |
| restoreDest | output | IDX_W | Register index to restore |
| restoreVal | output | DATA_W | Value to write back |
| recoverDone | output | 1 | Recovery complete pulse |
| recoverAddr | output | ADDR_W | Return address to save |
| recoverCause | output | CAUSE_W | Cause of the recovery |

## Verification
The bench fills the buffer and pushes past full. A design that miscounts here would either overwrite a live slot or report full one entry early. Finishes arrive in shuffled order with a simultaneous issue, so a design that retires a finished slot before an older unfinished one, or that stalls issue on a retirement, shows a wrong retire tag or a wrong ready. Each return address class is used with a branching next address, which exposes a design that confuses next address with address plus 4, or one that fails to keep an after-class faulting slot. Further cases cover an older exception racing both a younger exception and an asynchronous request, and an asynchronous request on an empty buffer just after reset. These catch wrong priority, wrong restore order, and a wrong fallback address.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Control-to-datapath strobes for one cycle
  typedef struct packed {
    logic issueWe;   // write payload into the tail slot
    logic retireEn;  // free the head slot
    logic finishEn;  // a finish report may be recorded
    logic undoEn;    // free the slot under the rollback cursor
  } hbStrobe_t;

  // Cause codes whose return address is not the faulting address
  localparam int CODE_SYSCALL  = 9;
  localparam int CODE_TRACE    = 10;
  localparam int CODE_DATA_BKP = 11;

endpackage

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 'h100,
  localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  hbStrobe_t          strobe,
  input  logic [TAG_W-1:0]   headPtr,
  input  logic [TAG_W-1:0]   tailPtr,
  input  logic [TAG_W-1:0]   walkPtr,
  input  logic [ADDR_W-1:0]  issueAddr,
  input  logic [ADDR_W-1:0]  issueNextAddr,
  input  logic [IDX_W-1:0]   issueDest,
  input  logic [DATA_W-1:0]  issueOldVal,
  input  logic [TAG_W-1:0]   finishTag,
  input  logic [CAUSE_W-1:0] finishCause,
  output logic               headFinished,
  output logic [CAUSE_W-1:0] headCause,
  output logic [ADDR_W-1:0]  headAddr,
  output logic [ADDR_W-1:0]  headNext,
  output logic [ADDR_W-1:0]  lastNext,
  output logic [IDX_W-1:0]   walkDest,
  output logic [DATA_W-1:0]  walkOld
);

  logic [DEPTH-1:0]   validVec;
  logic [DEPTH-1:0]   doneVec;
  logic [CAUSE_W-1:0] causeArr [DEPTH];

  logic [ADDR_W-1:0]  addrMem [DEPTH];
  logic [ADDR_W-1:0]  nextMem [DEPTH];
  logic [IDX_W-1:0]   destMem [DEPTH];
  logic [DATA_W-1:0]  oldMem  [DEPTH];

  // Per-slot status flags
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic               slotValid;
    logic               slotDone;
    logic [CAUSE_W-1:0] slotCause;
    logic               issueHit;
    logic               freeHit;
    logic               finishHit;

    assign issueHit  = strobe.issueWe  && (tailPtr == TAG_W'(g));
    assign freeHit   = (strobe.retireEn && (headPtr == TAG_W'(g))) ||
                       (strobe.undoEn   && (walkPtr == TAG_W'(g)));
    assign finishHit = strobe.finishEn && slotValid && (finishTag == TAG_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid <= 1'b0;
        slotDone  <= 1'b0;
        slotCause <= '0;
      end else begin
        if (issueHit)      slotValid <= 1'b1;
        else if (freeHit)  slotValid <= 1'b0;

        if (issueHit) begin
          slotDone  <= 1'b0;
          slotCause <= '0;
        end else if (finishHit) begin
          slotDone  <= 1'b1;
          slotCause <= finishCause;
        end
      end
    end

    assign validVec[g] = slotValid;
    assign doneVec[g]  = slotDone;
    assign causeArr[g] = slotCause;
  end

  // Payload storage, written once at issue
  always_ff @(posedge clk) begin
    if (strobe.issueWe) begin
      addrMem[tailPtr] <= issueAddr;
      nextMem[tailPtr] <= issueNextAddr;
      destMem[tailPtr] <= issueDest;
      oldMem[tailPtr]  <= issueOldVal;
    end
  end

  // Next address of the most recent retirement
  always_ff @(posedge clk) begin
    if (!rstN)                lastNext <= RESET_ADDR;
    else if (strobe.retireEn) lastNext <= nextMem[headPtr];
  end

  assign headFinished = validVec[headPtr] && doneVec[headPtr];
  assign headCause    = causeArr[headPtr];
  assign headAddr     = addrMem[headPtr];
  assign headNext     = nextMem[headPtr];
  assign walkDest     = destMem[walkPtr];
  assign walkOld      = oldMem[walkPtr];

endmodule

// File: rtl/hb_control.sv
module hb_control
  import hb_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int CAUSE_W = 4,
  localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic               finishValid,
  input  logic               asyncReq,
  input  logic [CAUSE_W-1:0] asyncCause,
  input  logic               headFinished,
  input  logic [CAUSE_W-1:0] headCause,
  input  logic [ADDR_W-1:0]  headAddr,
  input  logic [ADDR_W-1:0]  headNext,
  input  logic [ADDR_W-1:0]  lastNext,
  output hbStrobe_t          strobe,
  output logic [TAG_W-1:0]   headPtr,
  output logic [TAG_W-1:0]   tailPtr,
  output logic [TAG_W-1:0]   walkPtr,
  output logic               issueReady,
  output logic               bufFull,
  output logic               retireValid,
  output logic               restoreValid,
  output logic               recoverDone,
  output logic [ADDR_W-1:0]  recoverAddr,
  output logic [CAUSE_W-1:0] recoverCause
);

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DONE} hbState_t;

  localparam logic [CAUSE_W-1:0] SYS_C = CAUSE_W'(CODE_SYSCALL);
  localparam logic [CAUSE_W-1:0] TRC_C = CAUSE_W'(CODE_TRACE);
  localparam logic [CAUSE_W-1:0] DBK_C = CAUSE_W'(CODE_DATA_BKP);

  function automatic logic [TAG_W-1:0] ptrInc(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [TAG_W-1:0] ptrDec(input logic [TAG_W-1:0] p);
    return (p == '0) ? TAG_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  hbState_t           stateQ;
  logic [TAG_W-1:0]   headQ, tailQ, walkQ, stopQ;
  logic [CNT_W-1:0]   countQ;
  logic [ADDR_W-1:0]  savedQ;
  logic [CAUSE_W-1:0] causeQ;

  logic idle, headExc, excNext, excPlus4, excAfter;
  logic startExc, startAsync, startRec, issueFire, retireEn, undoEn;

  always_comb begin
    idle       = (stateQ == ST_IDLE);
    headExc    = headFinished && (headCause != '0);
    excNext    = (headCause == SYS_C) || (headCause == TRC_C);
    excPlus4   = (headCause == DBK_C);
    excAfter   = excNext || excPlus4;
    startExc   = idle && headExc;
    startAsync = idle && !headExc && asyncReq;
    startRec   = startExc || startAsync;
    bufFull    = (countQ == CNT_W'(DEPTH));
    issueReady = idle && !bufFull && !startRec;
    issueFire  = issueValid && issueReady;
    retireEn   = idle && headFinished && (headExc ? excAfter : !asyncReq);
    undoEn     = (stateQ == ST_WALK);

    strobe.issueWe  = issueFire;
    strobe.retireEn = retireEn;
    strobe.finishEn = finishValid && idle;
    strobe.undoEn   = undoEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      headQ  <= '0;
      tailQ  <= '0;
      walkQ  <= '0;
      stopQ  <= '0;
      countQ <= '0;
      savedQ <= '0;
      causeQ <= '0;
    end else begin
      unique case ({issueFire, retireEn || undoEn})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
      if (retireEn) headQ <= ptrInc(headQ);

      unique case (stateQ)
        ST_IDLE: begin
          if (issueFire) tailQ <= ptrInc(tailQ);
          if (startExc) begin
            causeQ <= headCause;
            if (!excAfter) begin
              savedQ <= headAddr;
              walkQ  <= ptrDec(tailQ);
              stopQ  <= headQ;
              stateQ <= ST_WALK;
            end else begin
              savedQ <= excPlus4 ? headAddr + ADDR_W'(4) : headNext;
              walkQ  <= ptrDec(tailQ);
              stopQ  <= ptrInc(headQ);
              stateQ <= (countQ == CNT_W'(1)) ? ST_DONE : ST_WALK;
            end
          end else if (startAsync) begin
            causeQ <= asyncCause;
            walkQ  <= ptrDec(tailQ);
            stopQ  <= headQ;
            if (countQ == '0) begin
              savedQ <= lastNext;
              stateQ <= ST_DONE;
            end else begin
              savedQ <= headAddr;
              stateQ <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (walkQ == stopQ) begin
            tailQ  <= walkQ;
            stateQ <= ST_DONE;
          end else begin
            walkQ <= ptrDec(walkQ);
          end
        end
        ST_DONE: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign headPtr      = headQ;
  assign tailPtr      = tailQ;
  assign walkPtr      = walkQ;
  assign retireValid  = retireEn;
  assign restoreValid = undoEn;
  assign recoverDone  = (stateQ == ST_DONE);
  assign recoverAddr  = savedQ;
  assign recoverCause = causeQ;

endmodule

// File: rtl/retire_history_buffer.sv
module retire_history_buffer
  import hb_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 'h100,
  localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [ADDR_W-1:0]  issueAddr,
  input  logic [ADDR_W-1:0]  issueNextAddr,
  input  logic [IDX_W-1:0]   issueDest,
  input  logic [DATA_W-1:0]  issueOldVal,
  output logic               issueReady,
  output logic [TAG_W-1:0]   issueTag,
  output logic               bufFull,
  input  logic               finishValid,
  input  logic [TAG_W-1:0]   finishTag,
  input  logic [CAUSE_W-1:0] finishCause,
  input  logic               asyncReq,
  input  logic [CAUSE_W-1:0] asyncCause,
  output logic               retireValid,
  output logic [TAG_W-1:0]   retireTag,
  output logic [ADDR_W-1:0]  retireAddr,
  output logic               restoreValid,
  output logic [IDX_W-1:0]   restoreDest,
  output logic [DATA_W-1:0]  restoreVal,
  output logic               recoverDone,
  output logic [ADDR_W-1:0]  recoverAddr,
  output logic [CAUSE_W-1:0] recoverCause
);

  hbStrobe_t          strobe;
  logic [TAG_W-1:0]   headPtr, tailPtr, walkPtr;
  logic               headFinished;
  logic [CAUSE_W-1:0] headCause;
  logic [ADDR_W-1:0]  headAddr, headNext, lastNext;

  hb_control #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .finishValid(finishValid),
    .asyncReq(asyncReq), .asyncCause(asyncCause),
    .headFinished(headFinished), .headCause(headCause),
    .headAddr(headAddr), .headNext(headNext), .lastNext(lastNext),
    .strobe(strobe), .headPtr(headPtr), .tailPtr(tailPtr), .walkPtr(walkPtr),
    .issueReady(issueReady), .bufFull(bufFull), .retireValid(retireValid),
    .restoreValid(restoreValid), .recoverDone(recoverDone),
    .recoverAddr(recoverAddr), .recoverCause(recoverCause)
  );

  hb_datapath #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
    .CAUSE_W(CAUSE_W), .RESET_ADDR(RESET_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .headPtr(headPtr), .tailPtr(tailPtr), .walkPtr(walkPtr),
    .issueAddr(issueAddr), .issueNextAddr(issueNextAddr),
    .issueDest(issueDest), .issueOldVal(issueOldVal),
    .finishTag(finishTag), .finishCause(finishCause),
    .headFinished(headFinished), .headCause(headCause),
    .headAddr(headAddr), .headNext(headNext), .lastNext(lastNext),
    .walkDest(restoreDest), .walkOld(restoreVal)
  );

  assign issueTag   = tailPtr;
  assign retireTag  = headPtr;
  assign retireAddr = headAddr;

endmodule

// File: rtl/hb_checker.sv
module hb_checker (
  input logic clk,
  input logic rstN,
  input logic issueReady,
  input logic bufFull,
  input logic retireValid,
  input logic restoreValid,
  input logic recoverDone
);

  // R2
  full_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> !issueReady);

  // R7
  walk_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |-> (!issueReady && !retireValid));

  // R12
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    recoverDone |=> !recoverDone);

  // R12
  walk_end_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(restoreValid) |-> recoverDone);

  // R3
  done_no_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    recoverDone |-> (!retireValid && !issueReady && !restoreValid));

endmodule

bind retire_history_buffer hb_checker u_hbChk (
  .clk(clk), .rstN(rstN), .issueReady(issueReady), .bufFull(bufFull),
  .retireValid(retireValid), .restoreValid(restoreValid),
  .recoverDone(recoverDone)
);

// File: tb/retire_history_buffer_bench.sv
`timescale 1ns/1ps
module retire_history_buffer_bench;

  localparam int DEPTH = 8;
  localparam logic [31:0] RST_ADDR = 32'h100;

  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [31:0] issueAddr, issueNextAddr, issueOldVal;
  logic [4:0]  issueDest;
  logic        issueReady, bufFull;
  logic [2:0]  issueTag;
  logic        finishValid;
  logic [2:0]  finishTag;
  logic [3:0]  finishCause;
  logic        asyncReq;
  logic [3:0]  asyncCause;
  logic        retireValid, restoreValid, recoverDone;
  logic [2:0]  retireTag;
  logic [31:0] retireAddr, restoreVal, recoverAddr;
  logic [4:0]  restoreDest;
  logic [3:0]  recoverCause;

  always #2.5 clk = ~clk;

  retire_history_buffer #(.DEPTH(DEPTH), .RESET_ADDR(RST_ADDR)) u_retire_history_buffer (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueAddr(issueAddr), .issueNextAddr(issueNextAddr),
    .issueDest(issueDest), .issueOldVal(issueOldVal),
    .issueReady(issueReady), .issueTag(issueTag), .bufFull(bufFull),
    .finishValid(finishValid), .finishTag(finishTag), .finishCause(finishCause),
    .asyncReq(asyncReq), .asyncCause(asyncCause),
    .retireValid(retireValid), .retireTag(retireTag), .retireAddr(retireAddr),
    .restoreValid(restoreValid), .restoreDest(restoreDest), .restoreVal(restoreVal),
    .recoverDone(recoverDone), .recoverAddr(recoverAddr), .recoverCause(recoverCause)
  );

  typedef struct {
    int          tag;
    logic [31:0] addr;
    logic [31:0] nxt;
    logic [4:0]  dest;
    logic [31:0] old;
    bit          done;
    logic [3:0]  cause;
  } ent_t;

  ent_t        q[$];
  int          mTail = 0;
  logic [31:0] mLastNext = RST_ADDR;
  int          mMode = 0;      // 0 idle, 1 rollback, 2 done pulse
  logic [31:0] mSaved = '0;
  logic [3:0]  mCause = '0;
  string       mReq = "R8";
  int          errors = 0;
  int          checks = 0;
  int          seq = 0;
  bit          ended = 0;

  function automatic int clsOf(input logic [3:0] c);
    if (c == 4'd9 || c == 4'd10) return 1;
    if (c == 4'd11) return 2;
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // One clock: compare outputs, take the edge, advance the reference model
  task automatic cyc();
    bit   hDone, hExc, idle, sExc, sAsy, eFull, eReady, eRet;
    int   cls;
    ent_t popped;
    #1;
    hDone  = (q.size() > 0) && q[0].done;
    hExc   = hDone && (q[0].cause != 4'd0);
    cls    = (q.size() > 0) ? clsOf(q[0].cause) : 0;
    idle   = (mMode == 0);
    sExc   = idle && hExc;
    sAsy   = idle && !hExc && asyncReq;
    eFull  = (q.size() == DEPTH);
    eReady = idle && !eFull && !sExc && !sAsy;
    eRet   = idle && hDone && (hExc ? (cls != 0) : !asyncReq);

    check("R2", 32'(issueReady), 32'(eReady), "issueReady");
    check("R2", 32'(bufFull), 32'(eFull), "bufFull");
    if (eReady) check("R1", 32'(issueTag), mTail, "issueTag");
    check("R3", 32'(retireValid), 32'(eRet), "retireValid");
    if (eRet) begin
      check("R3", 32'(retireTag), q[0].tag, "retireTag");
      check("R3", retireAddr, q[0].addr, "retireAddr");
    end
    check("R7", 32'(restoreValid), 32'(mMode == 1), "restoreValid");
    if (mMode == 1) begin
      check("R7", 32'(restoreDest), 32'(q[$].dest), "restoreDest");
      check("R7", restoreVal, q[$].old, "restoreVal");
    end
    check("R12", 32'(recoverDone), 32'(mMode == 2), "recoverDone");
    if (mMode == 2) begin
      check(mReq, recoverAddr, mSaved, "recoverAddr");
      check(mReq, 32'(recoverCause), 32'(mCause), "recoverCause");
    end

    @(posedge clk);
    // R5: finish only to an occupied slot while idle
    if (idle && finishValid)
      foreach (q[i]) if (q[i].tag == int'(finishTag)) begin
        q[i].done  = 1;
        q[i].cause = finishCause;
      end
    if (sExc) begin
      mCause = q[0].cause;
      case (cls)
        0:       begin mSaved = q[0].addr;      mReq = "R8";  end
        1:       begin mSaved = q[0].nxt;       mReq = "R9";  end
        default: begin mSaved = q[0].addr + 4;  mReq = "R10"; end
      endcase
      if (cls != 0) begin
        mLastNext = q[0].nxt;
        void'(q.pop_front());
      end
      mMode = (q.size() == 0) ? 2 : 1;
    end else if (sAsy) begin
      mCause = asyncCause;
      mReq   = "R11";
      mSaved = (q.size() > 0) ? q[0].addr : mLastNext;
      mMode  = (q.size() == 0) ? 2 : 1;
    end else if (eRet) begin
      mLastNext = q[0].nxt;
      void'(q.pop_front());
    end else if (mMode == 1) begin
      popped = q.pop_back();
      mTail  = popped.tag;
      if (q.size() == 0) mMode = 2;
    end else if (mMode == 2) begin
      mMode = 0;
    end
    if (issueValid && eReady) begin
      q.push_back('{tag: mTail, addr: issueAddr, nxt: issueNextAddr, dest: issueDest,
                    old: issueOldVal, done: 0, cause: 4'd0});
      mTail = (mTail + 1) % DEPTH;
    end
    @(negedge clk);
  endtask

  task automatic setIssue(input bit v, input bit br);
    issueValid = v;
    if (v) begin
      issueAddr     = 32'h1000 + 32'(seq) * 4;
      issueNextAddr = br ? (32'h9000 + 32'(seq) * 16) : (issueAddr + 4);
      issueDest     = 5'(seq * 7 + 1);
      issueOldVal   = 32'hA500_0000 + 32'(seq);
      seq++;
    end
  endtask

  task automatic issueN(input int n, input bit br);
    for (int i = 0; i < n; i++) begin
      setIssue(1, br);
      cyc();
    end
    issueValid = 0;
  endtask

  task automatic finishIdx(input int idx, input logic [3:0] c);
    finishValid = 1;
    finishTag   = 3'(q[idx].tag);
    finishCause = c;
    cyc();
    finishValid = 0;
  endtask

  task automatic runIdle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  // Finish every pending slot cleanly, youngest first, then drain
  task automatic finishAll();
    int pick;
    forever begin
      pick = -1;
      foreach (q[i]) if (!q[i].done) pick = i;
      if (pick < 0) break;
      finishIdx(pick, 4'd0);
    end
    runIdle(DEPTH + 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; issueValid = 0; issueAddr = '0; issueNextAddr = '0;
    issueDest = '0; issueOldVal = '0; finishValid = 0; finishTag = '0;
    finishCause = '0; asyncReq = 0; asyncCause = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R13: reset state
    check("R13", 32'(issueReady), 1, "reset issueReady");
    check("R13", 32'(issueTag), 0, "reset issueTag");
    check("R13", 32'(bufFull | retireValid | restoreValid | recoverDone), 0, "reset strobes");
    @(negedge clk);

    // R11: asynchronous request on an empty buffer right after reset
    asyncReq = 1; asyncCause = 4'hD;
    cyc();
    asyncReq = 0;
    runIdle(3);

    // R1 R2: fill past full, refused issues
    issueN(DEPTH + 2, 0);
    // R3 R4: out-of-order finishes while issuing into freed slots
    finishIdx(3, 0); finishIdx(1, 0); finishIdx(0, 0);
    setIssue(1, 0);
    finishIdx(2, 0); finishIdx(3, 0); finishIdx(7, 0);
    issueValid = 0;
    // R5: finish to an empty slot while the buffer holds live slots
    finishValid = 1; finishTag = 3'(mTail); finishCause = 4'd1;
    cyc();
    finishValid = 0;
    finishAll();

    // R6 R8: older alignment fault beats younger trap and a same-cycle async
    issueN(5, 0);
    finishIdx(3, 4'd5);
    finishIdx(1, 4'd3);
    finishIdx(4, 4'd0);
    finishIdx(0, 4'd0);
    cyc();                       // oldest retires
    asyncReq = 1; asyncCause = 4'hE;
    cyc();                       // exception at head wins over async
    asyncReq = 0;
    // R5 R7: finish during rollback is ignored, issue held off
    finishValid = 1; finishTag = 3'(mTail); finishCause = 4'd0;
    setIssue(1, 0);
    cyc();
    finishValid = 0;
    runIdle(6);
    issueValid = 0;
    finishAll();

    // R9: system call keeps the faulting slot, returns to branch target
    issueN(1, 1);
    issueN(2, 0);
    finishIdx(2, 4'd0);
    finishIdx(1, 4'd7);
    finishIdx(0, 4'd9);
    runIdle(6);

    // R9 R12: trace on a lone slot, nothing to restore
    issueN(1, 1);
    finishIdx(0, 4'd10);
    runIdle(3);

    // R10: data breakpoint uses address plus 4 even after a branch
    issueN(1, 1);
    issueN(1, 0);
    finishIdx(0, 4'd11);
    runIdle(4);

    // R11: async beats a same-cycle retirement, rolls back everything
    issueN(4, 0);
    finishIdx(2, 4'd0);
    finishIdx(0, 4'd0);
    asyncReq = 1; asyncCause = 4'hC;
    cyc();
    asyncReq = 0;
    runIdle(6);

    // R11: async on empty buffer uses next address of last retirement
    issueN(2, 1);
    finishAll();
    asyncReq = 1; asyncCause = 4'h2;
    cyc();
    asyncReq = 0;
    runIdle(3);

    // R8: before-class fault on a lone slot after pointer wrap
    issueN(1, 0);
    finishIdx(0, 4'd1);
    runIdle(4);

    ended = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule